// File: doc/BRIEF.md
# UART Modem Line Control and Status

This block holds the modem-side control register of a 16550-style serial port and produces the matching status byte. Software writes a control byte that drives four handshake outputs (DTR, RTS and two auxiliary outputs) and selects an internal loopback mode. The block reads the four handshake inputs (CTS, DSR, DCD, RI), records every change on them in sticky change flags, and returns levels and flags together in one status byte. A status read clears the flags.

Each input line passes through a synchroniser before any change is detected. After reset, the block waits until the synchroniser holds real pin levels before it arms change detection, so lines that are already asserted do not raise false change flags. In loopback mode the status levels come from the control register instead of the pins, and the external outputs are held inactive. Outside the block, an interrupt controller only needs the single `any_delta` flag.

Top module: `uart_modem_lines`

## Requirements
- R1: A write (`ctl_wr`=1 at a clock edge) stores `ctl_wdata[4:0]` as the control value: bit 0 DTR, bit 1 RTS, bit 2 AUX1, bit 3 AUX2, bit 4 loopback. `ctl_rdata` shows that value in bits 4:0, and bits 7:5 always read 0 whatever was written.
- R2: When loopback is off, `dtr_out`, `rts_out`, `aux1_out` and `aux2_out` (active high) equal control bits 0, 1, 2 and 3, starting the cycle after the write.
- R3: When loopback is on, all four output pins are 0.
- R4: When loopback is off, `sts_rdata[7:4]` = {DCD, RI, DSR, CTS} shows the pin levels with a latency of three clock edges (two synchroniser stages and the status register).
- R5: Status bits 3, 1 and 0 (change of DCD, DSR and CTS) are set when the registered level of their line changes in either direction. They stay set until a status read.
- R6: Status bit 2 is set only when the registered RI level goes from 1 to 0, and never when it goes from 0 to 1.
- R7: A status read (`sts_rd`=1 at an edge) clears all four change bits at that edge. A change detected at the same edge is still recorded.
- R8: When loopback is on, `sts_rdata[7:4]` takes DCD from AUX2, RI from AUX1, DSR from DTR and CTS from RTS, one edge after the control register, and the external input pins have no effect. Changes caused by entering or leaving loopback are flagged like any other change.
- R9: After reset the control value is 0x08 (AUX2 set) and the change bits are 0. The change bits stay 0 while the synchroniser fills, so pins held constant through reset never raise a flag.
- R10: `any_delta` is 1 exactly when at least one of `sts_rdata[3:0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| sts_rd | input | 1 | Status read strobe; clears change bits |
| cts_in | input | 1 | Clear-to-send line, active high |
| dsr_in | input | 1 | Data-set-ready line, active high |
| dcd_in | input | 1 | Carrier-detect line, active high |
| ri_in | input | 1 | Ring-indicator line, active high |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| aux1_out | output | 1 | Auxiliary output 1 |
| aux2_out | output | 1 | Auxiliary output 2 |
| ctl_rdata | output | 8 | Control register readback |
| sts_rdata | output | 8 | Status byte: levels in 7:4, change bits in 3:0 |
| any_delta | output | 1 | At least one change bit is set |

## Verification
The bench first holds every input asserted through reset. A design that armed change detection before the synchroniser filled would then show spurious change bits. It drives RI both high-to-low and low-to-high: a ring flag on the rising edge, or a ring flag missing on the falling edge, shows up at once. It reads the status in the same cycle as a pin change, which exposes a clear that wins over a new change and so loses an edge. It also enters and leaves loopback with patterns that tell apart each crossed pairing (AUX2 to DCD, AUX1 to RI, DTR to DSR, RTS to CTS), while toggling the real pins. This catches swapped mappings, outputs left driven, and pins that leak into the status.

// File: rtl/modem_lines_pkg.sv
// Shared constants and types for the modem line block.
// Control bit positions are fixed because software decodes them.
package modem_lines_pkg;
    localparam int CTL_BITS = 5;
    localparam int B_DTR    = 0;
    localparam int B_RTS    = 1;
    localparam int B_AUX1   = 2;
    localparam int B_AUX2   = 3;
    localparam int B_LOOP   = 4;
    localparam logic [CTL_BITS-1:0] CTL_RESET = 5'b01000;

    // Handshake line levels; packed order matches status bits 7:4.
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;
endpackage

// File: rtl/modem_line_sync.sv
// Multi-stage synchroniser for a group of asynchronous input lines.
// Assumes every line is a slow level signal; no bus coherency is implied.
module modem_line_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d_in;
                end
            end else begin : g_next
                // Shift through the remaining stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/modem_ctl_reg.sv
// Control register for the modem outputs and loopback selection.
// Assumes writes are single-cycle strobes; bits above the register width are dropped.
module modem_ctl_reg
    import modem_lines_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    output logic [CTL_BITS-1:0] ctl_q,
    output logic                dtr_pin,
    output logic                rts_pin,
    output logic                aux1_pin,
    output logic                aux2_pin
);
    logic unused_hi;
    assign unused_hi = ^wr_data[7:CTL_BITS];

    // Hold the control value; reset leaves only AUX2 asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= CTL_RESET;
        else if (wr_en) ctl_q <= wr_data[CTL_BITS-1:0];
    end

    // Drive the external outputs, forcing them inactive during loopback.
    always_comb begin
        dtr_pin  = ctl_q[B_DTR]  & ~ctl_q[B_LOOP];
        rts_pin  = ctl_q[B_RTS]  & ~ctl_q[B_LOOP];
        aux1_pin = ctl_q[B_AUX1] & ~ctl_q[B_LOOP];
        aux2_pin = ctl_q[B_AUX2] & ~ctl_q[B_LOOP];
    end

    // R1
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_q == $past(wr_data[CTL_BITS-1:0]));

    // R1
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/modem_status_track.sv
// Registers the selected line levels and accumulates sticky change flags.
// Assumes pin_lvl is already synchronised. Detection is held off for SETTLE
// edges after reset so the synchroniser can fill with real pin levels.
module modem_status_track
    import modem_lines_pkg::*;
#(
    parameter int SETTLE = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       loop_en,
    input  mline_t     pin_lvl,
    input  mline_t     loop_lvl,
    output mline_t     level_q,
    output logic [3:0] delta_q
);
    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] settle_cnt;
    logic          armed;
    mline_t        live;
    mline_t        chg;
    logic [3:0]    new_delta;

    assign armed = (settle_cnt == CW'(SETTLE));

    // Pick the level source and work out the changes seen this cycle.
    always_comb begin
        live      = loop_en ? loop_lvl : pin_lvl;
        chg       = level_q ^ live;
        new_delta = {chg.dcd, chg.ri & level_q.ri, chg.dsr, chg.cts};
    end

    // Count settle edges after reset, then stay armed.
    always_ff @(posedge clk) begin
        if (!rst_n)     settle_cnt <= '0;
        else if (!armed) settle_cnt <= settle_cnt + 1'b1;
    end

    // Track levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= live;
    end

    // Accumulate change flags; a read clears old flags but keeps new ones.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) delta_q <= '0;
        else                  delta_q <= (rd_en ? 4'b0 : delta_q) | new_delta;
    end

    // R6
    ring_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> ($past(level_q.ri) && !level_q.ri));

    // R5
    cts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[0]) |-> (level_q.cts != $past(level_q.cts)));

    // R5
    dcd_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[3]) |-> (level_q.dcd != $past(level_q.dcd)));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ((delta_q & ~(level_q ^ $past(level_q))) == 4'b0));

    // R9
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (delta_q == 4'b0));
endmodule

// File: rtl/uart_modem_lines.sv
// Modem control and status for a 16550-style serial port.
// Combines the control register, input synchroniser and change tracker,
// and provides the internal loopback cross-mapping of outputs to inputs.
module uart_modem_lines
    import modem_lines_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       sts_rd,
    input  logic       cts_in,
    input  logic       dsr_in,
    input  logic       dcd_in,
    input  logic       ri_in,
    output logic       dtr_out,
    output logic       rts_out,
    output logic       aux1_out,
    output logic       aux2_out,
    output logic [7:0] ctl_rdata,
    output logic [7:0] sts_rdata,
    output logic       any_delta
);
    localparam int SETTLE = SYNC_STAGES + 1;

    logic [CTL_BITS-1:0] ctl_q;
    mline_t              raw_lvl;
    mline_t              sync_lvl;
    mline_t              loop_lvl;
    mline_t              level_q;
    logic [3:0]          delta_q;

    assign raw_lvl = '{dcd: dcd_in, ri: ri_in, dsr: dsr_in, cts: cts_in};

    modem_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr),
        .wr_data  (ctl_wdata),
        .ctl_q    (ctl_q),
        .dtr_pin  (dtr_out),
        .rts_pin  (rts_out),
        .aux1_pin (aux1_out),
        .aux2_pin (aux2_out)
    );

    modem_line_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_lvl),
        .q_out (sync_lvl)
    );

    // Loopback cross-mapping: AUX2->DCD, AUX1->RI, DTR->DSR, RTS->CTS.
    always_comb begin
        loop_lvl.dcd = ctl_q[B_AUX2];
        loop_lvl.ri  = ctl_q[B_AUX1];
        loop_lvl.dsr = ctl_q[B_DTR];
        loop_lvl.cts = ctl_q[B_RTS];
    end

    modem_status_track #(.SETTLE(SETTLE)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (sts_rd),
        .loop_en  (ctl_q[B_LOOP]),
        .pin_lvl  (sync_lvl),
        .loop_lvl (loop_lvl),
        .level_q  (level_q),
        .delta_q  (delta_q)
    );

    // Assemble the register read values.
    always_comb begin
        ctl_rdata = {{(8-CTL_BITS){1'b0}}, ctl_q};
        sts_rdata = {level_q, delta_q};
        any_delta = |delta_q;
    end

    // R3
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[B_LOOP] |-> !(dtr_out || rts_out || aux1_out || aux2_out));

    // R8
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_rdata[B_LOOP]) |-> (sts_rdata[7:4] ==
            {$past(ctl_rdata[B_AUX2]), $past(ctl_rdata[B_AUX1]),
             $past(ctl_rdata[B_DTR]),  $past(ctl_rdata[B_RTS])}));
endmodule

// File: tb/uart_modem_lines_test.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module uart_modem_lines_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       sts_rd = 1'b0;
    logic [3:0] pins = 4'h0;   // {dcd, ri, dsr, cts}
    logic       dtr_out, rts_out, aux1_out, aux2_out, any_delta;
    logic [7:0] ctl_rdata, sts_rdata;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    uart_modem_lines uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .sts_rd(sts_rd), .cts_in(pins[0]), .dsr_in(pins[1]),
        .dcd_in(pins[3]), .ri_in(pins[2]),
        .dtr_out(dtr_out), .rts_out(rts_out), .aux1_out(aux1_out),
        .aux2_out(aux2_out), .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata),
        .any_delta(any_delta)
    );

    // Reference model state.
    logic [4:0] m_ctl;
    logic [3:0] m_hist [$];
    logic [3:0] m_lvl, m_dl;
    int         m_age;

    always @(posedge clk) begin
        logic [3:0] live, ch, nd, synced;
        if (!rst_n) begin
            m_ctl = 5'h08; m_lvl = 4'h0; m_dl = 4'h0; m_age = 0;
            m_hist = '{4'h0, 4'h0};
        end else begin
            synced = m_hist[0];
            live = m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]} : synced;
            if (m_age < 3) begin
                m_dl = 4'h0;
                m_age++;
            end else begin
                ch = m_lvl ^ live;
                nd = {ch[3], ch[2] & m_lvl[2], ch[1], ch[0]};
                m_dl = (sts_rd ? 4'h0 : m_dl) | nd;
            end
            m_lvl = live;
            void'(m_hist.pop_front());
            m_hist.push_back(pins);
            if (ctl_wr) m_ctl = ctl_wdata[4:0];
        end
    end

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Cycle compare against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1", "control readback", ctl_rdata, {3'b000, m_ctl});
            if (m_ctl[4]) begin
                chk("R3", "outputs in loopback", {aux2_out, aux1_out, rts_out, dtr_out}, 0);
                chk("R8", "loopback levels", sts_rdata[7:4], m_lvl);
            end else begin
                chk("R2", "outputs", {aux2_out, aux1_out, rts_out, dtr_out}, m_ctl[3:0]);
                chk("R4", "pin levels", sts_rdata[7:4], m_lvl);
            end
            chk("R5", "line change bits", {sts_rdata[3], sts_rdata[1:0]}, {m_dl[3], m_dl[1:0]});
            chk("R6", "ring trailing bit", sts_rdata[2], m_dl[2]);
            chk("R10", "any_delta", any_delta, |m_dl);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; step(1); ctl_wr = 1'b0;
    endtask

    task automatic rd_sts();
        sts_rd = 1'b1; step(1); sts_rd = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        pins = 4'hF;
        step(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step(8);
        // R9: reset value and quiet flags with pins held high through reset
        chk("R9", "control after reset", ctl_rdata, 8'h08);
        chk("R9", "change bits after reset", sts_rdata[3:0], 0);

        // Single-line changes, each followed by a read.
        pins = 4'hE; step(5); rd_sts(); step(2);   // CTS falls
        pins = 4'hC; step(5); rd_sts(); step(2);   // DSR falls
        pins = 4'h4; step(5); rd_sts(); step(2);   // DCD falls
        pins = 4'h0; step(5);                       // RI 1->0
        chk("R6", "ring fall flagged", sts_rdata[2], 1);
        rd_sts(); step(1);
        chk("R7", "flags cleared by read", sts_rdata[3:0], 0);
        pins = 4'h4; step(5);                       // RI 0->1
        chk("R6", "ring rise not flagged", sts_rdata[2], 0);

        // Read in the same cycle a change lands.
        pins = 4'h5; step(2); rd_sts(); step(1);
        chk("R7", "change kept over read", sts_rdata[0], 1);
        rd_sts(); step(2);

        // Control writes, including high bits that must be dropped.
        wr_ctl(8'hE3); step(2);
        wr_ctl(8'h0C); step(2);

        // Loopback patterns while real pins toggle.
        wr_ctl(8'h1F); pins = 4'h0; step(3);
        wr_ctl(8'h18); pins = 4'hF; step(3);
        wr_ctl(8'h14); step(3);
        wr_ctl(8'h11); pins = 4'h3; step(3);
        wr_ctl(8'h12); step(3); rd_sts(); step(2);
        chk("R8", "pins ignored in loopback", sts_rdata[3:0], 0);
        wr_ctl(8'h00); step(6); rd_sts(); step(2);

        // Random mix.
        for (int i = 0; i < 600; i++) begin
            pins      = 4'($urandom);
            sts_rd    = ($urandom % 4) == 0;
            ctl_wr    = ($urandom % 8) == 0;
            ctl_wdata = 8'($urandom);
            step(1);
        end
        ctl_wr = 1'b0; sts_rd = 1'b0;
        step(5);

        summary();
        $finish;
    end
endmodule